// File: doc/BRIEF.md
# Dual-Class Fixed-Priority Interrupt Controller

This block gathers 22 level-type interrupt sources and turns them into two processor request lines: a fast request and a normal request. Seventeen sources come from on-chip peripherals as active-high levels. Five come from board pins, and each pin has its own polarity. Every source has its own enable bit. The class of a source is fixed by its index. Inside each class, a fixed order picks the winning source, and software reads its number from the register port.

No source is latched. A pending bit simply tracks the condition of its input, so a request drops as soon as the peripheral or pin lets go of it. The register port is a plain synchronous write strobe with an address and write data, plus a read-data bus that is driven combinationally from the selected address.

Top module: `dual_irq_ctrl`

## Requirements
- R1: While reset is held and after it is released, the enable register reads 0, both request outputs are low, and both winner indices read 31.
- R2: `fiq_o` is high in the cycle after a clock edge exactly when at least one of sources 0 to 3 was asserted and enabled at that edge.
- R3: `irq_o` is high in the cycle after a clock edge exactly when at least one of sources 4 to 21 was asserted and enabled at that edge.
- R4: An asserted source whose enable bit is 0 has no effect on either request output or on either winner index.
- R5: Address 2 returns the fast winner in bits 4:0 and address 3 returns the normal winner in bits 4:0. The winner is the lowest-numbered source of that class that was asserted and enabled at the last edge, or 31 if there is none. The upper bits read 0.
- R6: `ext_pin[k]` is source k for k = 0 to 4. Pins 0, 1, 3 and 4 are asserted when low. Pin 2 is asserted when high. `int_src[j]` is source j+5 and is asserted when high.
- R7: Sources are level-sensitive. A request or winner drops one edge after its source deasserts, and nothing is held once the input is gone.
- R8: Address 1 returns the asserted state of all 22 sources in bits 21:0, as sampled at the last edge and regardless of enables. Bits 31:22 read 0.
- R9: A write with `wr_en` high at address 0 loads `wdata` into the enable register (bit n enables source n) at that edge. Address 0 reads it back in bits 21:0, with bits 31:22 reading 0. Writes to the other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_src | input | 17 | Peripheral interrupt levels, active high (sources 5..21) |
| ext_pin | input | 5 | Board interrupt pins with mixed polarity (sources 0..4) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 22 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| fiq_o | output | 1 | Fast request to the processor |
| irq_o | output | 1 | Normal request to the processor |

## Verification
Every result is due one clock edge after the inputs it depends on are sampled. Both request outputs, the status bits and the two winner indices reflect the source levels present at the previous rising edge. An enable write shows up in read-back right after the writing edge, but it takes effect on the requests one edge later. The bench drives inputs on the falling edge and updates its reference model on each rising edge in that same order. It then compares the requests and the read data for the current address on the next falling edge, so each result is sampled in exactly the cycle in which it is due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int          IDX_W    = 5;
  localparam logic [4:0]  IDX_NONE = 5'd31;

  // Lowest set bit of v within [lo, hi], or IDX_NONE when the range is empty.
  function automatic logic [IDX_W-1:0] first_set(input logic [31:0] v,
                                                 input int lo, input int hi);
    logic [IDX_W-1:0] r;
    r = IDX_NONE;
    for (int i = hi; i >= lo; i--) begin
      if (v[i]) r = i[IDX_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int                NUM_INT = 17,
  parameter int                NUM_EXT = 5,
  parameter logic [NUM_EXT-1:0] EXT_LOW = 5'b11011,
  localparam int               NUM_SRC = NUM_INT + NUM_EXT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_src,
  input  logic [NUM_EXT-1:0] ext_pin,
  output logic [NUM_SRC-1:0] pend_d,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_EXT-1:0] ext_active;

  // Active-low pins are inverted so every source reads 1 when asserted.
  assign ext_active = ext_pin ^ EXT_LOW;
  assign pend_d     = {int_src, ext_active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_class_arb.sv
module irq_class_arb
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 22,
  parameter int LO      = 0,
  parameter int HI      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_d,
  input  logic [NUM_SRC-1:0] en_q,
  output logic               req_q,
  output logic [IDX_W-1:0]   idx_q
);
  logic [NUM_SRC-1:0] class_mask;
  logic [NUM_SRC-1:0] live;
  logic               any_live;
  logic [IDX_W-1:0]   win;

  always_comb begin
    class_mask = '0;
    for (int i = LO; i <= HI; i++) class_mask[i] = 1'b1;
  end

  assign live     = pend_d & en_q & class_mask;
  assign any_live = |live;
  assign win      = first_set(32'(pend_d & en_q), LO, HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= IDX_NONE;
    end else begin
      req_q <= any_live;
      idx_q <= win;
    end
  end

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(|(en_q & class_mask))); // R4
  AST_IDX_IN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_NONE) || (int'(idx_q) >= LO && int'(idx_q) <= HI)); // R5
  AST_IDX_AGREES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != IDX_NONE) == req_q); // R5
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 22,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic [IDX_W-1:0]   fast_idx,
  input  logic [IDX_W-1:0]   norm_idx,
  output logic [NUM_SRC-1:0] en_q,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [1:0] A_EN = 2'd0, A_STAT = 2'd1, A_FAST = 2'd2, A_NORM = 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     en_q <= '0;
    else if (wr_en && addr == A_EN) en_q <= wdata;
  end

  always_comb begin
    unique case (addr)
      A_EN:    rdata = DATA_W'(en_q);
      A_STAT:  rdata = DATA_W'(pend_q);
      A_FAST:  rdata = DATA_W'(fast_idx);
      default: rdata = DATA_W'(norm_idx);
    endcase
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == A_EN) |-> en_q == $past(wdata)); // R9
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(wr_en && addr == A_EN)) |-> $stable(en_q)); // R9
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irq_pkg::*;
#(
  parameter int          NUM_INT  = 17,
  parameter int          NUM_EXT  = 5,
  parameter int          NUM_FAST = 4,
  parameter logic [4:0]  EXT_LOW  = 5'b11011,
  parameter int          DATA_W   = 32,
  localparam int         NUM_SRC  = NUM_INT + NUM_EXT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_src,
  input  logic [NUM_EXT-1:0] ext_pin,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               fiq_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend_d, pend_q, en_q;
  logic [1:0]         cls_req;
  logic [IDX_W-1:0]   cls_idx [2];

  irq_src_cond #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT), .EXT_LOW(EXT_LOW)) u_cond (
    .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_pin(ext_pin),
    .pend_d(pend_d), .pend_q(pend_q));

  // Class 0 = fast (sources 0..NUM_FAST-1), class 1 = normal (the rest).
  for (genvar c = 0; c < 2; c++) begin : g_cls
    localparam int LO = (c == 0) ? 0 : NUM_FAST;
    localparam int HI = (c == 0) ? NUM_FAST - 1 : NUM_SRC - 1;
    irq_class_arb #(.NUM_SRC(NUM_SRC), .LO(LO), .HI(HI)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .en_q(en_q),
      .req_q(cls_req[c]), .idx_q(cls_idx[c]));
  end

  irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_q(pend_q), .fast_idx(cls_idx[0]), .norm_idx(cls_idx[1]),
    .en_q(en_q), .rdata(rdata));

  assign fiq_o = cls_req[0];
  assign irq_o = cls_req[1];

  AST_QUIET_UNTIL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) == '0) |-> (!fiq_o && !irq_o)); // R1
  AST_FAST_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_d[NUM_FAST-1:0]) == '0) |-> !fiq_o); // R7
endmodule

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] int_src = '0;
  logic [4:0]  ext_pin = 5'b11011;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [21:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq_o, irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit [21:0] m_en, m_pend;
  bit        m_fiq, m_irq;
  int        m_fidx = 31, m_nidx = 31;

  dual_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_pin(ext_pin),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .fiq_o(fiq_o), .irq_o(irq_o));

  always #10ns clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [21:0] asserted_now();
    bit [21:0] s;
    for (int k = 0; k < 5; k++) s[k] = (k == 2) ? ext_pin[k] : !ext_pin[k];
    for (int j = 0; j < 17; j++) s[j+5] = int_src[j];
    return s;
  endfunction

  task automatic model_edge();
    bit [21:0] s, live;
    s = asserted_now();
    live = s & m_en;
    m_fiq = 0; m_irq = 0; m_fidx = 31; m_nidx = 31;
    for (int i = 21; i >= 0; i--) begin
      if (live[i]) begin
        if (i < 4) begin m_fiq = 1; m_fidx = i; end
        else       begin m_irq = 1; m_nidx = i; end
      end
    end
    m_pend = s;
    if (wr_en && addr == 2'd0) m_en = wdata;
  endtask

  task automatic compare();
    longint exp_rd;
    chk("R2 fiq_o", fiq_o, m_fiq);
    chk("R3 irq_o", irq_o, m_irq);
    case (addr)
      2'd0: begin exp_rd = m_en;   chk("R9 enable readback", rdata, exp_rd); end
      2'd1: begin exp_rd = m_pend; chk("R8 status readback", rdata, exp_rd); end
      2'd2: begin exp_rd = m_fidx; chk("R5 fast winner", rdata, exp_rd); end
      default: begin exp_rd = m_nidx; chk("R5 normal winner", rdata, exp_rd); end
    endcase
  endtask

  task automatic cyc();
    @(posedge clk); model_edge();
    @(negedge clk); compare();
  endtask

  task automatic wr_en_reg(input bit [21:0] v);
    wr_en = 1; addr = 2'd0; wdata = v; cyc();
    wr_en = 0;
  endtask

  task automatic rd(input bit [1:0] a);
    addr = a; #1ns;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 fiq reset", fiq_o, 0); chk("R1 irq reset", irq_o, 0);
    rd(2'd2); chk("R1 fast idx reset", rdata, 31);
    rd(2'd3); chk("R1 normal idx reset", rdata, 31);
    rd(2'd0); chk("R1 enable reset", rdata, 0);
    rst_n = 1;
    // R4: all sources asserted, nothing enabled
    int_src = '1; ext_pin = 5'b00100;
    repeat (3) cyc();
    chk("R4 masked fiq", fiq_o, 0); chk("R4 masked irq", irq_o, 0);
    rd(2'd1); chk("R8 raw status unmasked", rdata, 32'h3FFFFF);
    rd(2'd2); chk("R4 masked fast idx", rdata, 31);
    // R6: pin 2 is active high, others active low
    int_src = '0; ext_pin = 5'b11011;
    wr_en_reg(22'h3FFFFF);
    ext_pin = 5'b11111; cyc(); cyc();
    chk("R6 pin2 high asserts", fiq_o, 1);
    rd(2'd2); chk("R6 fast idx pin2", rdata, 2);
    ext_pin = 5'b01011; cyc();
    chk("R6 pin4 low asserts normal", irq_o, 1);
    rd(2'd3); chk("R6 normal idx pin4", rdata, 4);
    // R5: priority within the normal class
    ext_pin = 5'b11011; int_src = 17'h10010; rd(2'd3); cyc();
    chk("R5 lowest normal wins", rdata, 9);
    // R7: level, no latching
    int_src = '0; cyc();
    chk("R7 irq drops", irq_o, 0);
    chk("R7 normal idx clears", rdata, 31);
    // R4: disable the winner, next one takes over
    int_src = 17'h10010; cyc();
    wr_en_reg(22'h3FFFFF & ~22'h200); rd(2'd3); cyc();
    chk("R4 disabled winner skipped", rdata, 21);
    // R9: writes elsewhere ignored
    wr_en = 1; addr = 2'd1; wdata = '0; cyc(); wr_en = 0;
    rd(2'd0); chk("R9 write to status ignored", rdata, 32'h3FFDFF);
    // random phase with per-cycle comparison
    for (int n = 0; n < 3000; n++) begin
      int_src = 17'($urandom) & 17'($urandom);
      ext_pin = 5'($urandom);
      addr = 2'($urandom);
      wr_en = ($urandom % 8) == 0;
      wdata = 22'($urandom) & 22'($urandom);
      cyc();
    end
    wr_en = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule